// File: doc/BRIEF.md
# Configuration memory reset sequencer

This block sequences reset and standby for a serial memory that supplies configuration data to a programmable device at power-up. The memory shares a single open-drain line with the device it feeds. That line is both the memory's output-enable and a reset. While the supplies come up, the sequencer pulls the line low. It keeps the line low until the core supply has passed its power-on threshold and, if enabled, the output supply is also good. It then waits a further fixed margin and releases the line, which lets the external pull-up raise it and start configuration.

After release, the sequencer watches the line and an active-low chip enable, both resynchronised through a two-stage flop chain. A high chip enable puts the block in standby, whatever level the line has. A low line with chip enable asserted holds the block in reset. In both cases the read address counter is cleared, the cascade output is held high and the data drivers are turned off. A core-supply power-down flag sends the block back to the start of the sequence from any state. A small stand-in address counter steps on a read strobe and marks the last word on the cascade output.

Top module: `cfg_rst_seq`

## Requirements
- R1: `pin_pull_low` is 1 exactly in states POWER_UP and DELAY. The block has no way to drive the line high: it can only pull it low or let it go, so an outside agent may hold the line low at any time.
- R2: After the edge that moves the block from POWER_UP to DELAY, the block stays in DELAY for exactly `DELAY_CYCLES` clock edges, with the line pulled low throughout. It then releases the line, provided the supplies stay qualified and no power-down is seen.
- R3: Supplies qualify when `core_por_ok` is 1 and, if `NEED_IO` is 1, `io_ok` is also 1. With `NEED_IO`=1, a missing `io_ok` keeps the block in POWER_UP indefinitely.
- R4: `core_pd`=1 moves the block to POWER_UP at the next edge from any state, and the delay restarts from zero. In DELAY, losing supply qualification also returns the block to POWER_UP. After release, only `core_pd` triggers the return.
- R5: After release, if `ce_n` is low and the synchronised line is low, the block is in EXT_RESET. In that state `data_drive_en`=0, `cascade_n`=1 and `rd_addr`=0. It returns to ACTIVE once the synchronised line reads high.
- R6: After release, a synchronised `ce_n`=1 selects STANDBY whatever the level of the line. Standby has the same quiet outputs as EXT_RESET.
- R7: `ce_n` and `pin_sense` each pass through two flops. A change applied before edge k changes the state at edge k+2. The first edge after release therefore enters EXT_RESET, and ACTIVE follows three edges later.
- R8: In ACTIVE, `rd_addr` steps by one on each edge where `rd_adv`=1, and holds at `WORDS-1`. It is cleared on the same edge on which the block leaves ACTIVE.
- R9: `cascade_n` is 0 only in ACTIVE with `rd_addr` = `WORDS-1`. Otherwise it is 1.
- R10: `seq_state` encodes POWER_UP=0, DELAY=1, ACTIVE=2, STANDBY=3, EXT_RESET=4.
- R11: While `rst_n`=0, the block is in POWER_UP with `rd_addr`=0. The synchroniser for `ce_n` resets to 1 and the synchroniser for `pin_sense` resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencing logic |
| core_por_ok | input | 1 | Core supply above its power-on threshold |
| core_pd | input | 1 | Core supply below its power-down threshold |
| io_ok | input | 1 | Output supply at operating level |
| pin_sense | input | 1 | Sampled level of the shared open-drain reset line |
| ce_n | input | 1 | Active-low chip enable |
| rd_adv | input | 1 | Read strobe that steps the address counter |
| pin_pull_low | output | 1 | 1 pulls the shared line low, 0 releases it |
| data_drive_en | output | 1 | Enable of the data output drivers |
| cascade_n | output | 1 | Active-low cascade enable for the next memory |
| rd_addr | output | AW | Read address counter |
| seq_state | output | 3 | Encoded sequencer state |

## Verification
The bench goes after the release margin and measures it in edges, both on a clean ramp and after a power-down pulse in the middle of the delay. A counter that is off by one, or that does not restart, shows up as a release one or more cycles early or late. It holds the line low from outside after release, and a block that fought the line or kept its data drivers on would show `pin_pull_low` or `data_drive_en` set. It raises chip enable while the line is held low. A block that let the line win would sit in EXT_RESET instead of STANDBY and would come back to ACTIVE as soon as the line rose. A behavioural model is compared on every clock, so an extra or missing synchroniser stage shifts the state by a cycle and is caught.

// File: rtl/cfg_rst_pkg.sv
package cfg_rst_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP  = 3'd0,
    ST_MARGIN = 3'd1,
    ST_RUN    = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_HELD   = 3'd4
  } seq_state_t;

  // Supplies are good enough to start the margin timer.
  function automatic logic supplies_good(input logic core_ok, input logic io_good,
                                         input logic need_io);
    return core_ok & (io_good | ~need_io);
  endfunction

  // State chosen once the line has been released: standby beats the line.
  function automatic seq_state_t settle_state(input logic ce_high, input logic line_low);
    if (ce_high)       return ST_SLEEP;
    else if (line_low) return ST_HELD;
    else               return ST_RUN;
  endfunction

  // Next address value while reading.
  function automatic int unsigned addr_step(input int unsigned cur, input logic adv,
                                            input int unsigned last);
    return (adv && cur != last) ? cur + 1 : cur;
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_rst_fsm.sv
module cfg_rst_fsm
  import cfg_rst_pkg::*;
#(
  parameter int DELAY_CYCLES = 1000,
  localparam int CNT_W = $clog2(DELAY_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supplies_ok,
  input  logic       core_pd,
  input  logic       ce_high_s,
  input  logic       pin_low_s,
  output seq_state_t state_q,
  output seq_state_t state_d,
  output logic       margin_done
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign margin_done = (state_q == ST_MARGIN) && (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_PWRUP: begin
        if (supplies_ok && !core_pd) begin
          state_d = ST_MARGIN;
          cnt_d   = '0;
        end
      end
      ST_MARGIN: begin
        if (core_pd || !supplies_ok) state_d = ST_PWRUP;
        else if (margin_done)        state_d = settle_state(ce_high_s, pin_low_s);
        else                         cnt_d   = cnt_q + CNT_W'(1);
      end
      default: begin
        if (core_pd) state_d = ST_PWRUP;
        else         state_d = settle_state(ce_high_s, pin_low_s);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWRUP;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/cfg_rst_addr.sv
module cfg_rst_addr #(
  parameter int WORDS = 4096,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_now,
  input  logic          run_next,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          at_end
);
  localparam int unsigned LAST = WORDS - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr <= '0;
    else if (!run_next) addr <= '0;
    else if (run_now)   addr <= AW'(cfg_rst_pkg::addr_step(int'(addr), adv, LAST));
  end

  assign at_end = (int'(addr) == LAST);
endmodule

// File: rtl/cfg_rst_seq.sv
module cfg_rst_seq
  import cfg_rst_pkg::*;
#(
  parameter int DELAY_CYCLES = 1000,
  parameter int WORDS        = 4096,
  parameter bit NEED_IO      = 1'b1,
  parameter int SYNC_STAGES  = 2,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_por_ok,
  input  logic          core_pd,
  input  logic          io_ok,
  input  logic          pin_sense,
  input  logic          ce_n,
  input  logic          rd_adv,
  output logic          pin_pull_low,
  output logic          data_drive_en,
  output logic          cascade_n,
  output logic [AW-1:0] rd_addr,
  output logic [2:0]    seq_state
);
  // Named internal events, also used by the bound checker.
  logic       supplies_ok;
  logic       ce_high_s;
  logic       pin_high_s;
  logic       pin_low_s;
  logic       margin_done;
  logic       addr_at_end;
  seq_state_t st_q, st_d;

  assign supplies_ok = supplies_good(core_por_ok, io_ok, NEED_IO);

  cfg_rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ce (
    .clk(clk), .rst_n(rst_n), .d(ce_n), .q(ce_high_s)
  );

  cfg_rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pin (
    .clk(clk), .rst_n(rst_n), .d(pin_sense), .q(pin_high_s)
  );

  assign pin_low_s = ~pin_high_s;

  cfg_rst_fsm #(.DELAY_CYCLES(DELAY_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .supplies_ok(supplies_ok), .core_pd(core_pd),
    .ce_high_s(ce_high_s), .pin_low_s(pin_low_s),
    .state_q(st_q), .state_d(st_d), .margin_done(margin_done)
  );

  cfg_rst_addr #(.WORDS(WORDS)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .run_now(st_q == ST_RUN), .run_next(st_d == ST_RUN), .adv(rd_adv),
    .addr(rd_addr), .at_end(addr_at_end)
  );

  assign pin_pull_low  = (st_q == ST_PWRUP) || (st_q == ST_MARGIN);
  assign data_drive_en = (st_q == ST_RUN);
  assign cascade_n     = ~((st_q == ST_RUN) && addr_at_end);
  assign seq_state     = st_q;
endmodule

// File: rtl/cfg_rst_seq_chk.sv
module cfg_rst_seq_chk #(
  parameter int DELAY_CYCLES = 1000,
  parameter int WORDS        = 4096,
  parameter bit NEED_IO      = 1'b1,
  localparam int AW = $clog2(WORDS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_por_ok,
  input logic          core_pd,
  input logic          io_ok,
  input logic          rd_adv,
  input logic          supplies_ok,
  input logic          ce_high_s,
  input logic          pin_low_s,
  input logic          margin_done,
  input logic          pin_pull_low,
  input logic          data_drive_en,
  input logic          cascade_n,
  input logic [AW-1:0] rd_addr,
  input logic [2:0]    seq_state
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  // Consecutive cycles with the line held and supplies qualified.
  logic [31:0] qual_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qual_run <= '0;
    else if (pin_pull_low && supplies_ok && !core_pd)
      qual_run <= (qual_run == 32'hFFFF_FFFF) ? qual_run : qual_run + 32'd1;
    else qual_run <= '0;
  end

  p_pd_pulls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_pd |=> pin_pull_low);

  p_release_margin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_pull_low) |-> (qual_run >= 32'(DELAY_CYCLES)));

  p_margin_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (margin_done && supplies_ok && !core_pd) |=> !pin_pull_low);

  p_both_supplies_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_pull_low) |-> $past(core_por_ok && (io_ok || !NEED_IO)));

  p_standby_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_high_s && !pin_pull_low && !core_pd) |=> (seq_state == 3'd3));

  p_line_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_low_s && !ce_high_s && !pin_pull_low && !core_pd) |=> (seq_state == 3'd4));

  p_quiet_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !data_drive_en |-> (rd_addr == '0 && cascade_n));

  p_cascade_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cascade_n |-> (data_drive_en && rd_addr == LAST));

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_drive_en && $past(data_drive_en) && $past(rd_adv) && ($past(rd_addr) != LAST))
      |-> (rd_addr == $past(rd_addr) + AW'(1)));
endmodule

bind cfg_rst_seq cfg_rst_seq_chk #(
  .DELAY_CYCLES(DELAY_CYCLES), .WORDS(WORDS), .NEED_IO(NEED_IO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .core_por_ok(core_por_ok), .core_pd(core_pd),
  .io_ok(io_ok), .rd_adv(rd_adv), .supplies_ok(supplies_ok),
  .ce_high_s(ce_high_s), .pin_low_s(pin_low_s), .margin_done(margin_done),
  .pin_pull_low(pin_pull_low), .data_drive_en(data_drive_en),
  .cascade_n(cascade_n), .rd_addr(rd_addr), .seq_state(seq_state)
);

// File: tb/tb_cfg_rst_seq.sv
`timescale 1ns/1ps
module tb_cfg_rst_seq;
  localparam int D     = 20;
  localparam int WORDS = 16;
  localparam bit NEED  = 1'b1;
  localparam int AW    = $clog2(WORDS);

  logic clk = 1'b0;
  logic rst_n, core_por_ok, core_pd, io_ok, ce_n, rd_adv, ext_hold;
  logic pin_sense;
  logic pin_pull_low, data_drive_en, cascade_n;
  logic [AW-1:0] rd_addr;
  logic [2:0] seq_state;

  int checks = 0;
  int bad = 0;
  bit chk_on = 1'b0;

  always #2.5 clk = ~clk;

  // Open-drain line: pulled up unless the block or an outside agent pulls low.
  assign pin_sense = !pin_pull_low && !ext_hold;

  cfg_rst_seq #(.DELAY_CYCLES(D), .WORDS(WORDS), .NEED_IO(NEED)) dut (
    .clk(clk), .rst_n(rst_n), .core_por_ok(core_por_ok), .core_pd(core_pd),
    .io_ok(io_ok), .pin_sense(pin_sense), .ce_n(ce_n), .rd_adv(rd_adv),
    .pin_pull_low(pin_pull_low), .data_drive_en(data_drive_en),
    .cascade_n(cascade_n), .rd_addr(rd_addr), .seq_state(seq_state)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  int m_st = 0, m_cnt = 0, m_addr = 0;
  int ce_q[$]  = '{1, 1};
  int pin_q[$] = '{0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_addr = 0;
      ce_q = '{1, 1}; pin_q = '{0, 0};
    end else begin
      int nxt, settle, line_now;
      bit good;
      line_now = (m_st <= 1 || ext_hold) ? 0 : 1;
      good = core_por_ok && (io_ok || !NEED);
      settle = (ce_q[1] == 1) ? 3 : ((pin_q[1] == 0) ? 4 : 2);
      nxt = m_st;
      if (m_st == 0) begin
        if (good && !core_pd) begin nxt = 1; m_cnt = 0; end
      end else if (m_st == 1) begin
        if (core_pd || !good) nxt = 0;
        else if (m_cnt == D - 1) nxt = settle;
        else m_cnt++;
      end else begin
        nxt = core_pd ? 0 : settle;
      end
      if (nxt != 2) m_addr = 0;
      else if (m_st == 2 && rd_adv && m_addr < WORDS - 1) m_addr++;
      void'(ce_q.pop_back());  ce_q.push_front(int'(ce_n));
      void'(pin_q.pop_back()); pin_q.push_front(line_now);
      m_st = nxt;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      check(int'(seq_state) == m_st, "R10 state vs model", int'(seq_state), m_st);
      check(int'(pin_pull_low) == int'(m_st <= 1), "R1 pull-low vs model",
            int'(pin_pull_low), int'(m_st <= 1));
      check(int'(data_drive_en) == int'(m_st == 2), "R5 data enable vs model",
            int'(data_drive_en), int'(m_st == 2));
      check(int'(rd_addr) == m_addr, "R8 address vs model", int'(rd_addr), m_addr);
      check(int'(cascade_n) == int'(!(m_st == 2 && m_addr == WORDS - 1)),
            "R9 cascade vs model", int'(cascade_n), int'(!(m_st == 2 && m_addr == WORDS - 1)));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic time_release(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (pin_pull_low && n < 1000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int n;
    rst_n = 0; core_por_ok = 0; core_pd = 1; io_ok = 0;
    ce_n = 0; rd_adv = 0; ext_hold = 0;
    step(3);
    check(seq_state == 3'd0, "R11 reset state", int'(seq_state), 0);
    check(pin_pull_low == 1'b1, "R11 reset pull-low", int'(pin_pull_low), 1);
    check(data_drive_en == 1'b0 && cascade_n == 1'b1 && rd_addr == '0,
          "R11 reset outputs quiet", int'(data_drive_en), 0);
    rst_n = 1;
    step(1);
    chk_on = 1;

    // R3: core good but output supply missing keeps POWER_UP.
    core_pd = 0; core_por_ok = 1;
    step(30);
    check(seq_state == 3'd0 && pin_pull_low, "R3 waits for io supply", int'(seq_state), 0);

    // R2: margin measured in edges.
    io_ok = 1;
    time_release(n);
    check(n == D + 1, "R2 release timing clean ramp", n, D + 1);
    check(seq_state == 3'd4, "R7 first state after release", int'(seq_state), 4);
    step(2);
    check(seq_state == 3'd4, "R7 sync latency held", int'(seq_state), 4);
    step(1);
    check(seq_state == 3'd2, "R7 active after sync", int'(seq_state), 2);

    // R8/R9: counting and saturation.
    rd_adv = 1;
    step(5);
    check(int'(rd_addr) == 5, "R8 address steps", int'(rd_addr), 5);
    step(20);
    check(int'(rd_addr) == WORDS - 1, "R8 address saturates", int'(rd_addr), WORDS - 1);
    check(cascade_n == 1'b0, "R9 cascade at last word", int'(cascade_n), 0);
    rd_adv = 0;

    // R5: outside agent holds the line low.
    ext_hold = 1;
    step(2);
    check(seq_state == 3'd2, "R7 hold not yet seen", int'(seq_state), 2);
    step(1);
    check(seq_state == 3'd4, "R5 external hold enters reset", int'(seq_state), 4);
    check(rd_addr == '0 && cascade_n && !data_drive_en, "R5 quiet in external reset",
          int'(rd_addr), 0);
    check(pin_pull_low == 1'b0, "R1 no pull during external hold", int'(pin_pull_low), 0);

    // R6: chip enable high wins over the low line.
    ce_n = 1;
    step(3);
    check(seq_state == 3'd3, "R6 standby over held line", int'(seq_state), 3);
    ext_hold = 0;
    step(5);
    check(seq_state == 3'd3, "R6 line release ignored in standby", int'(seq_state), 3);
    ce_n = 0;
    step(3);
    check(seq_state == 3'd2 && rd_addr == '0, "R6 leave standby to active", int'(seq_state), 2);

    // R4: power dip, then a second dip in the middle of the delay.
    core_pd = 1;
    step(1);
    check(seq_state == 3'd0 && pin_pull_low, "R4 dip re-enters power-up", int'(seq_state), 0);
    core_pd = 0;
    step(10);
    check(seq_state == 3'd1, "R2 in delay", int'(seq_state), 1);
    core_pd = 1;
    step(1);
    check(seq_state == 3'd0, "R4 dip mid delay", int'(seq_state), 0);
    core_pd = 0;
    time_release(n);
    check(n == D + 1, "R4 delay restarts in full", n, D + 1);
    step(4);

    // R4: after release only the power-down flag matters.
    core_por_ok = 0;
    step(3);
    check(seq_state == 3'd2, "R4 por loss after release ignored", int'(seq_state), 2);
    core_por_ok = 1;
    core_pd = 1;
    step(1);
    core_pd = 0;
    step(5);
    check(seq_state == 3'd1, "R4 delay running", int'(seq_state), 1);
    io_ok = 0;
    step(1);
    check(seq_state == 3'd0, "R3 io loss in delay restarts", int'(seq_state), 0);
    step(5);
    io_ok = 1;
    time_release(n);
    check(n == D + 1, "R3 release after io return", n, D + 1);
    step(10);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule